// File: doc/BRIEF.md
# Backward State-Metric Recursion Engine

This block performs the backward pass of a min-sum (max-log) soft-input decoder for an eight-state recursive systematic convolutional code. One start command runs a loop of recursion steps. In each step the engine steps its channel-memory pointer down by one and reads a soft systematic value and a soft parity value. It forms four branch costs and, for every trellis state, adds each branch cost to the metric of the successor state and keeps the smaller of the two sums. It rescales the eight results so that the smallest is zero, then writes the vector to a metric memory one slot below the previous one.

The trellis has feedback taps 1+D²+D³ and forward taps 1+D+D³. A state is the 3-bit vector {d1,d2,d3}. For input bit u the feedback bit is a = u^d2^d3, the parity bit is a^d1^d3, and the next state is {a,d1,d2}. The metric registers are seeded from an initial vector when the command starts. A rate setting chooses between using every parity value and a punctured pattern. Steps follow each other with no gap, and a one-cycle done pulse marks the final store, which is the point where the issuing sequencer may move on.

Top module: `bwd_metric_engine`

## Requirements
- R1: While rst_ni is low and after release with no start, ch_rd_en_o, sm_we_o and done_o are 0.
- R2: A start_i seen while idle latches count, source address, metric base, rate and the initial metric vector (state s at bits [12s+11:12s]). A start_i that arrives while a loop is running has no effect.
- R3: Step k (from 0) reads channel address src_addr_i-1-k modulo 2^AW, with exactly one read per step.
- R4: Step k writes its metric vector to sm_base_i-1-k modulo 2^SAW, one cycle after its read, while that read's data is on ch_rdata_i.
- R5: A channel word holds the systematic value in bits [7:0] and the parity value in bits [15:8], both two's complement. Each value is sign-extended to 12 bits before any sum. The branch cost for (u,p) is u·sys + p·par.
- R6: With rate_i=0 every parity value is used. With rate_i=1 the parity is taken as 0 when the read address is odd.
- R7: The new metric of state s is the minimum over u in {0,1} of old_metric[next(s,u)] + cost(u, parity(s,u)), using the trellis above.
- R8: Each candidate sum saturates at 2047. The stored vector is the eight minima minus their smallest value, saturated at 2047. Every stored metric lies in [0,2047] and at least one is 0.
- R9: A count of N runs N steps, and a count of 0 runs one step. Consecutive steps are two cycles apart with no idle cycle.
- R10: done_o pulses for one cycle, in the same cycle as the final write. After it the engine issues no read or write until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a recursion loop (ignored while busy) |
| count_i | input | CNTW | Number of steps |
| src_addr_i | input | AW | Channel address one above the first read |
| sm_base_i | input | SAW | Metric address one above the first write |
| rate_i | input | 1 | 0: all parity used, 1: parity punctured at odd addresses |
| init_sm_i | input | 8*SMW | Initial metric vector |
| ch_rd_en_o | output | 1 | Channel memory read strobe |
| ch_addr_o | output | AW | Channel memory address |
| ch_rdata_i | input | 2*CVW | Channel word, one cycle after the read |
| sm_we_o | output | 1 | Metric memory write strobe |
| sm_addr_o | output | SAW | Metric memory address |
| sm_wdata_o | output | 8*SMW | New metric vector |
| done_o | output | 1 | Final step stored |

## Verification
The final metric store and the done pulse share a cycle. A new start_i can also arrive in the same cycle as a step of a loop that is still running. The scoreboard checks that done_o is high on the write its expected item marks as last and low on every other write. One run pulses start_i with different addresses and rate in the middle of the loop. That run is judged by its reads and writes following only the first command, and by both strobes staying low once the queue is empty. Saturation, sign extension of -128 operands, address wrap at zero and puncturing each have a directed run checked against a behavioural recursion.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int NUM_ST = 8;

  // state = {d1,d2,d3}; feedback 1+D^2+D^3, forward 1+D+D^3
  function automatic logic fb_bit(input logic [2:0] s, input logic u);
    return u ^ s[1] ^ s[0];
  endfunction

  function automatic logic [2:0] next_st(input logic [2:0] s, input logic u);
    return {fb_bit(s, u), s[2], s[1]};
  endfunction

  function automatic logic par_bit(input logic [2:0] s, input logic u);
    return fb_bit(s, u) ^ s[2] ^ s[0];
  endfunction
endpackage

// File: rtl/bwd_branch.sv
module bwd_branch #(
  parameter int CVW = 8,
  parameter int SMW = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    rate_i,
  input  logic                    addr_lsb_i,
  input  logic [2*CVW-1:0]        ch_word_i,
  output logic [3:0][SMW-1:0]     gamma_o
);
  localparam int EXT = SMW - CVW;

  logic signed [SMW-1:0] ls, lp;
  logic                  punct;

  assign punct = rate_i & addr_lsb_i;
  // widen before adding
  assign ls = {{EXT{ch_word_i[CVW-1]}}, ch_word_i[CVW-1:0]};
  assign lp = punct ? '0 : {{EXT{ch_word_i[2*CVW-1]}}, ch_word_i[2*CVW-1:CVW]};

  // index {u,p}
  assign gamma_o[0] = '0;
  assign gamma_o[1] = lp;
  assign gamma_o[2] = ls;
  assign gamma_o[3] = ls + lp;

  a_r6_punct_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rate_i && addr_lsb_i) |-> (gamma_o[1] == '0));

  a_r5_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (gamma_o[2][SMW-1] == ch_word_i[CVW-1]));
endmodule

// File: rtl/bwd_acs.sv
module bwd_acs
  import bwd_pkg::*;
#(
  parameter int SMW = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [NUM_ST-1:0][SMW-1:0]  beta_i,
  input  logic [3:0][SMW-1:0]         gamma_i,
  output logic [NUM_ST-1:0][SMW-1:0]  beta_o
);
  localparam int XW = SMW + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((1 << (SMW-1)) - 1);

  function automatic logic signed [XW-1:0] sx(input logic [SMW-1:0] v);
    return {{(XW-SMW){v[SMW-1]}}, v};
  endfunction

  logic signed [XW-1:0] sel [NUM_ST];
  logic signed [XW-1:0] mn;
  logic [NUM_ST-1:0]    zero_f, neg_f;

  for (genvar s = 0; s < NUM_ST; s++) begin : g_acs
    localparam logic [2:0] N0 = next_st(3'(s), 1'b0);
    localparam logic [2:0] N1 = next_st(3'(s), 1'b1);
    localparam logic       P0 = par_bit(3'(s), 1'b0);
    localparam logic       P1 = par_bit(3'(s), 1'b1);
    logic signed [XW-1:0] c0, c1, s0, s1;
    assign c0 = sx(beta_i[N0]) + sx(gamma_i[{1'b0, P0}]);
    assign c1 = sx(beta_i[N1]) + sx(gamma_i[{1'b1, P1}]);
    assign s0 = (c0 > MAXV) ? MAXV : c0;
    assign s1 = (c1 > MAXV) ? MAXV : c1;
    assign sel[s] = (s1 < s0) ? s1 : s0;
  end

  always_comb begin
    mn = sel[0];
    for (int s = 1; s < NUM_ST; s++)
      if (sel[s] < mn) mn = sel[s];
  end

  for (genvar s = 0; s < NUM_ST; s++) begin : g_norm
    logic signed [XW-1:0] d;
    assign d         = sel[s] - mn;
    assign beta_o[s] = (d > MAXV) ? MAXV[SMW-1:0] : d[SMW-1:0];
    assign zero_f[s] = (beta_o[s] == '0);
    assign neg_f[s]  = beta_o[s][SMW-1];
  end

  a_r8_has_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (zero_f != '0));

  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (neg_f == '0));
endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl #(
  parameter int AW   = 10,
  parameter int SAW  = 8,
  parameter int CNTW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CNTW-1:0] count_i,
  input  logic [AW-1:0]   src_i,
  input  logic [SAW-1:0]  base_i,
  input  logic            rate_i,
  output logic            load_o,
  output logic            calc_o,
  output logic            rate_o,
  output logic            addr_lsb_o,
  output logic            ch_rd_en_o,
  output logic [AW-1:0]   ch_addr_o,
  output logic            sm_we_o,
  output logic [SAW-1:0]  sm_addr_o,
  output logic            done_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CALC} st_e;

  st_e             st_q;
  logic [AW-1:0]   src_q;
  logic [SAW-1:0]  off_q;
  logic [CNTW-1:0] cnt_q;
  logic            rate_q;
  logic            last;

  assign last = (cnt_q <= CNTW'(1));  // count 0 runs once

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
      rate_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          src_q  <= src_i;
          off_q  <= base_i;
          cnt_q  <= count_i;
          rate_q <= rate_i;
          st_q   <= ST_RD;
        end
        ST_RD: begin
          src_q <= src_q - 1'b1;
          st_q  <= ST_CALC;
        end
        ST_CALC: begin
          off_q <= off_q - 1'b1;
          cnt_q <= cnt_q - 1'b1;
          st_q  <= last ? ST_IDLE : ST_RD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o     = (st_q == ST_IDLE) && start_i;
  assign calc_o     = (st_q == ST_CALC);
  assign rate_o     = rate_q;
  assign addr_lsb_o = src_q[0];  // already the read address in CALC
  assign ch_rd_en_o = (st_q == ST_RD);
  assign ch_addr_o  = src_q - 1'b1;
  assign sm_we_o    = calc_o;
  assign sm_addr_o  = off_q - 1'b1;
  assign done_o     = calc_o && last;

  a_r4_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_rd_en_o |=> (sm_we_o && !ch_rd_en_o));

  a_r9_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_we_o && !done_o) |=> ch_rd_en_o);

  a_r4_off_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_we_o && !done_o) |=> ##1 (sm_addr_o == SAW'($past(sm_addr_o, 2) - 1'b1)));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_rd_en_o |=> ##1 (!ch_rd_en_o || (ch_addr_o == AW'($past(ch_addr_o, 2) - 1'b1))));

  a_r10_done_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sm_we_o);

  a_r10_quiet_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!ch_rd_en_o && !sm_we_o && !done_o));
endmodule

// File: rtl/bwd_metric_engine.sv
module bwd_metric_engine
  import bwd_pkg::*;
#(
  parameter int CVW  = 8,
  parameter int SMW  = 12,
  parameter int AW   = 10,
  parameter int SAW  = 8,
  parameter int CNTW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CNTW-1:0]       count_i,
  input  logic [AW-1:0]         src_addr_i,
  input  logic [SAW-1:0]        sm_base_i,
  input  logic                  rate_i,
  input  logic [NUM_ST*SMW-1:0] init_sm_i,
  output logic                  ch_rd_en_o,
  output logic [AW-1:0]         ch_addr_o,
  input  logic [2*CVW-1:0]      ch_rdata_i,
  output logic                  sm_we_o,
  output logic [SAW-1:0]        sm_addr_o,
  output logic [NUM_ST*SMW-1:0] sm_wdata_o,
  output logic                  done_o
);
  logic [NUM_ST-1:0][SMW-1:0] beta_q, beta_nxt;
  logic [3:0][SMW-1:0]        gamma;
  logic load, calc, rate_q, addr_lsb;

  bwd_ctrl #(.AW(AW), .SAW(SAW), .CNTW(CNTW)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .count_i,
    .src_i      (src_addr_i),
    .base_i     (sm_base_i),
    .rate_i,
    .load_o     (load),
    .calc_o     (calc),
    .rate_o     (rate_q),
    .addr_lsb_o (addr_lsb),
    .ch_rd_en_o, .ch_addr_o, .sm_we_o, .sm_addr_o, .done_o
  );

  bwd_branch #(.CVW(CVW), .SMW(SMW)) i_branch (
    .clk_i, .rst_ni,
    .valid_i    (calc),
    .rate_i     (rate_q),
    .addr_lsb_i (addr_lsb),
    .ch_word_i  (ch_rdata_i),
    .gamma_o    (gamma)
  );

  bwd_acs #(.SMW(SMW)) i_acs (
    .clk_i, .rst_ni,
    .valid_i (calc),
    .beta_i  (beta_q),
    .gamma_i (gamma),
    .beta_o  (beta_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   beta_q <= '0;
    else if (load) beta_q <= init_sm_i;
    else if (calc) beta_q <= beta_nxt;
  end

  assign sm_wdata_o = beta_nxt;

  a_r1_idle_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!ch_rd_en_o && !sm_we_o && !done_o));
endmodule

// File: tb/test_bwd_metric_engine.sv
module test_bwd_metric_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  typedef struct {
    int          rd;
    int          wr;
    logic [95:0] data;
    bit          last;
    bit          first;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [9:0]  src_addr_i = '0;
  logic [7:0]  sm_base_i = '0;
  logic        rate_i = 1'b0;
  logic [95:0] init_sm_i = '0;
  logic        ch_rd_en_o, sm_we_o, done_o;
  logic [9:0]  ch_addr_o;
  logic [15:0] ch_rdata_i = '0;
  logic [7:0]  sm_addr_o;
  logic [95:0] sm_wdata_o;

  logic [15:0] mem [1024];
  item_t       q [$];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          last_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ch_rd_en_o) ch_rdata_i <= mem[ch_addr_o];
  end

  bwd_metric_engine i_bwd_metric_engine (
    .clk_i(clk), .rst_ni, .start_i, .count_i, .src_addr_i, .sm_base_i,
    .rate_i, .init_sm_i, .ch_rd_en_o, .ch_addr_o, .ch_rdata_i,
    .sm_we_o, .sm_addr_o, .sm_wdata_o, .done_o
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // monitor: pop expected items as the design writes
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ch_rd_en_o) begin
        if (q.size() == 0) check(1'b0, "R2", "read with nothing pending", 96'(ch_addr_o), 0);
        else check(int'(ch_addr_o) == q[0].rd, "R3", "read address",
                   96'(ch_addr_o), 96'(q[0].rd));
      end
      if (sm_we_o) begin
        if (q.size() == 0) check(1'b0, "R2", "write with nothing pending", 96'(sm_addr_o), 0);
        else begin
          item_t it;
          it = q.pop_front();
          check(int'(sm_addr_o) == it.wr, "R4", "write address", 96'(sm_addr_o), 96'(it.wr));
          check(sm_wdata_o == it.data, it.tag, "metric vector", sm_wdata_o, it.data);
          check(done_o == it.last, "R10", "done on write", 96'(done_o), 96'(it.last));
          if (!it.first)
            check(cyc - last_wr == 2, "R9", "step spacing", 96'(cyc - last_wr), 96'd2);
          last_wr = cyc;
        end
      end else if (done_o) begin
        check(1'b0, "R10", "done without write", 96'(done_o), 0);
      end
    end
  end

  function automatic int sv8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic do_run(input int n, input int src, input int off, input bit rate,
                        input int init[NS], input string tag, input bit poke);
    int beta[NS];
    int nb[NS];
    int iters, a, ls, lp, mn, best, nsx, fb, p, g, c, d;
    logic [15:0] w;
    item_t it;
    beta  = init;
    iters = (n == 0) ? 1 : n;
    for (int k = 0; k < iters; k++) begin
      a  = (src - 1 - k) & 1023;
      w  = mem[a];
      ls = sv8(w[7:0]);
      lp = (rate && (a % 2 == 1)) ? 0 : sv8(w[15:8]);
      mn = 1 << 30;
      for (int s = 0; s < NS; s++) begin
        best = 1 << 30;
        for (int u = 0; u < 2; u++) begin
          fb  = u ^ ((s >> 1) & 1) ^ (s & 1);
          nsx = (fb << 2) | (s >> 1);
          p   = fb ^ ((s >> 2) & 1) ^ (s & 1);
          g   = u * ls + p * lp;
          c   = beta[nsx] + g;
          if (c > 2047) c = 2047;
          if (c < best) best = c;
        end
        nb[s] = best;
        if (best < mn) mn = best;
      end
      for (int s = 0; s < NS; s++) begin
        d = nb[s] - mn;
        if (d > 2047) d = 2047;
        beta[s] = d;
        it.data[s*12 +: 12] = 12'(d);
      end
      it.rd = a; it.wr = (off - 1 - k) & 255;
      it.last = (k == iters - 1); it.first = (k == 0); it.tag = tag;
      q.push_back(it);
    end
    for (int s = 0; s < NS; s++) init_sm_i[s*12 +: 12] = 12'(init[s]);
    count_i = 16'(n); src_addr_i = 10'(src); sm_base_i = 8'(off); rate_i = rate;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      count_i = 16'd9; src_addr_i = 10'd500; sm_base_i = 8'd77; rate_i = ~rate;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!ch_rd_en_o && !sm_we_o, poke ? "R2" : "R10", "idle after loop",
            96'({ch_rd_en_o, sm_we_o}), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int init[NS];
    for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    check(!ch_rd_en_o && !sm_we_o && !done_o, "R1", "outputs in reset",
          96'({ch_rd_en_o, sm_we_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!ch_rd_en_o && !sm_we_o && !done_o, "R1", "idle after reset",
          96'({ch_rd_en_o, sm_we_o, done_o}), 0);

    // R7 single step, random seed metrics
    for (int s = 0; s < NS; s++) init[s] = int'($urandom % 300);
    do_run(1, 300, 50, 1'b0, init, "R7", 1'b0);
    // R7 / R3 wrap through address 0
    do_run(5, 2, 3, 1'b0, init, "R7", 1'b0);
    // R6 punctured
    do_run(6, 41, 120, 1'b1, init, "R6", 1'b0);
    // R9 count of zero runs one step
    do_run(0, 700, 200, 1'b0, init, "R9", 1'b0);
    // R5 most negative operands
    for (int i = 97; i < 100; i++) mem[i] = 16'h8080;
    for (int s = 0; s < NS; s++) init[s] = 0;
    do_run(3, 100, 90, 1'b0, init, "R5", 1'b0);
    // R8 saturation of candidate sums
    for (int i = 198; i < 200; i++) mem[i] = {8'd120, 8'd120};
    for (int s = 0; s < NS; s++) init[s] = 2047;
    init[0] = 1500;
    do_run(2, 200, 10, 1'b0, init, "R8", 1'b0);
    // R2 start during a running loop
    for (int s = 0; s < NS; s++) init[s] = int'($urandom % 100);
    do_run(4, 600, 180, 1'b0, init, "R2", 1'b0 | 1'b1);
    // long punctured loop
    do_run(20, 900, 250, 1'b1, init, "R6", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule